// File: doc/BRIEF.md
# NAND Random Column Read Sequencer

This block sits on the host side of an 8-bit asynchronous NAND flash bus. It takes read requests from a local client and turns them into command, address and data-strobe cycles on the flash pins. The bytes it reads come back to the client on a plain valid/ready stream.

A request of the first kind names a row, a start column and a byte count. The block loads that page into the device's data register and then streams the requested bytes. A request of the second kind, the column jump, names only a new column and a count. It re-points the device's output pointer inside the page already loaded and streams from there, with no new array access. A client can issue any number of jumps after one page load. A jump is refused with an error flag when no page is loaded.

Strobe widths, the write-to-read turnaround, the settle delay before ready/busy is watched, and a busy timeout are all parameters given in clock cycles. If the device stays busy past the limit, the block raises a fault and forgets the page.

Top module: `nand_colread_seq`

## Requirements
- R1: A page request (req_jump=0) produces six write cycles. The first is a command cycle (CLE high) carrying 0x00. Next come four address cycles (ALE high) carrying column bits 7:0, column bits 15:8 (zero-extended), row bits 7:0 and row bits 15:8, in that order. The last is a command cycle carrying 0x30. CLE and ALE are never high together.
- R2: After the 0x30 cycle, RE# stays high while ready/busy is low, and no byte is read until ready/busy returns high.
- R3: After a page load, exactly req_cnt RE# pulses occur. The byte sampled on each pulse is delivered on the output stream in pulse order.
- R4: A jump request (req_jump=1) with a page loaded produces four write cycles: command 0x05, address column bits 7:0, address column bits 15:8, then command 0x E0 written as 0xE0. No 0x00 or 0x30 is written and ready/busy is not waited on.
- R5: Jumps may be repeated any number of times after one page load. Each jump returns req_cnt bytes starting at its own column.
- R6: A jump request accepted while no page is loaded causes no bus cycle. It sets err_nopage the cycle after acceptance and holds it until the next accepted request, and req_ready stays high.
- R7: If ready/busy stays low for BUSY_MAX cycles while a page loads, busy_fault is set and held until the next accepted request. The block returns to idle and reads no bytes, and the page is treated as not loaded, so a following jump is refused.
- R8: Each RE# low pulse lasts exactly RE_LO cycles, RE# stays high at least RE_HI cycles between pulses, and the first RE# fall comes at least WHR cycles after the last WE# rise. The I/O bus is not driven while RE# is low.
- R9: While out_valid is high and out_ready low, out_valid stays high and out_data is unchanged, and no byte is lost under backpressure.
- R10: A request with req_cnt=0 sends its write cycles, makes no RE# pulse, and returns to idle.
- R11: After reset, req_ready is high, out_valid, err_nopage and busy_fault are low, WE# and RE# are high, and CLE and ALE are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_jump | input | 1 | 0 = page load, 1 = column jump |
| req_row | input | ROW_W | Row address (page load only) |
| req_col | input | COL_W | Start column |
| req_cnt | input | CNT_W | Bytes to read |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer takes byte |
| out_data | output | 8 | Output byte |
| err_nopage | output | 1 | Last jump refused, no page loaded |
| busy_fault | output | 1 | Ready/busy timeout on last page load |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | I/O bus value driven |
| nand_io_oe | output | 1 | I/O bus output enable |
| nand_io_in | input | 8 | I/O bus value from device |
| nand_rb_n | input | 1 | Ready/busy, low = busy |

## Verification
Two functions can land in the same cycle: the RE# strobe engine finishing a byte, and the consumer holding off the output stream. The bench provokes this by driving out_ready randomly, and sometimes mostly low, during page reads and chains of jumps. It judges the result in two ways. Every delivered byte must match the page content expected at its column, and out_data must stay constant while a byte waits. The bench also measures every RE# low and high run in cycles against the configured widths. The ready/busy wait and the busy timeout are exercised with a device model whose busy time is set below and above the limit.

// File: rtl/nand_colread_seq.sv
module nand_colread_seq #(
  parameter int COL_W    = 12,
  parameter int ROW_W    = 16,
  parameter int CNT_W    = 12,
  parameter int WE_LO    = 2,
  parameter int WE_HI    = 2,
  parameter int RE_LO    = 2,
  parameter int RE_HI    = 2,
  parameter int WHR      = 3,
  parameter int TWB      = 2,
  parameter int BUSY_MAX = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_jump,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             err_nopage,
  output logic             busy_fault,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb_n
);
  localparam int TW = 8;
  localparam int BW = $clog2(BUSY_MAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WLO, S_WHI, S_WB, S_RB, S_TURN, S_RLO, S_RHI, S_OUT
  } st_t;

  st_t              state;
  logic [2:0]       step;
  logic [TW-1:0]    tmr;
  logic [BW-1:0]    bcnt;
  logic [CNT_W-1:0] rem;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic             jump_q;
  logic             page_loaded;
  logic [7:0]       data_q;
  logic             err_q, fault_q;
  logic [15:0]      col16, row16;
  logic [7:0]       bus_byte;
  logic             is_cmd, last_step, in_write;

  assign col16     = 16'(col_q);
  assign row16     = 16'(row_q);
  assign last_step = jump_q ? (step == 3'd3) : (step == 3'd5);
  assign is_cmd    = (step == 3'd0) || last_step;
  assign in_write  = (state == S_WLO) || (state == S_WHI);

  always_comb begin
    if (jump_q) begin
      case (step)
        3'd0:    bus_byte = 8'h05;
        3'd1:    bus_byte = col16[7:0];
        3'd2:    bus_byte = col16[15:8];
        default: bus_byte = 8'hE0;
      endcase
    end else begin
      case (step)
        3'd0:    bus_byte = 8'h00;
        3'd1:    bus_byte = col16[7:0];
        3'd2:    bus_byte = col16[15:8];
        3'd3:    bus_byte = row16[7:0];
        3'd4:    bus_byte = row16[15:8];
        default: bus_byte = 8'h30;
      endcase
    end
  end

  assign req_ready   = (state == S_IDLE);
  assign out_valid   = (state == S_OUT);
  assign out_data    = data_q;
  assign err_nopage  = err_q;
  assign busy_fault  = fault_q;
  assign nand_we_n   = (state != S_WLO);
  assign nand_re_n   = (state != S_RLO);
  assign nand_cle    = in_write && is_cmd;
  assign nand_ale    = in_write && !is_cmd;
  assign nand_io_oe  = in_write;
  assign nand_io_out = in_write ? bus_byte : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      step        <= '0;
      tmr         <= '0;
      bcnt        <= '0;
      rem         <= '0;
      col_q       <= '0;
      row_q       <= '0;
      jump_q      <= 1'b0;
      page_loaded <= 1'b0;
      data_q      <= '0;
      err_q       <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          err_q   <= 1'b0;
          fault_q <= 1'b0;
          if (req_jump && !page_loaded) begin
            err_q <= 1'b1;
          end else begin
            jump_q <= req_jump;
            col_q  <= req_col;
            rem    <= req_cnt;
            if (!req_jump) begin
              row_q       <= req_row;
              page_loaded <= 1'b0;
            end
            step  <= '0;
            tmr   <= '0;
            state <= S_WLO;
          end
        end
        S_WLO: if (tmr == TW'(WE_LO - 1)) begin
          tmr   <= '0;
          state <= S_WHI;
        end else tmr <= tmr + 1'b1;
        S_WHI: if (tmr == TW'(WE_HI - 1)) begin
          tmr <= '0;
          if (last_step) state <= jump_q ? S_TURN : S_WB;
          else begin
            step  <= step + 1'b1;
            state <= S_WLO;
          end
        end else tmr <= tmr + 1'b1;
        S_WB: if (tmr == TW'(TWB - 1)) begin
          tmr   <= '0;
          bcnt  <= '0;
          state <= S_RB;
        end else tmr <= tmr + 1'b1;
        S_RB: if (nand_rb_n) begin
          page_loaded <= 1'b1;
          tmr         <= '0;
          state       <= S_TURN;
        end else if (bcnt == BW'(BUSY_MAX - 1)) begin
          fault_q <= 1'b1;
          state   <= S_IDLE;
        end else bcnt <= bcnt + 1'b1;
        S_TURN: if (tmr == TW'(WHR - 1)) begin
          tmr   <= '0;
          state <= (rem == '0) ? S_IDLE : S_RLO;
        end else tmr <= tmr + 1'b1;
        S_RLO: if (tmr == TW'(RE_LO - 1)) begin
          tmr    <= '0;
          data_q <= nand_io_in;
          state  <= S_RHI;
        end else tmr <= tmr + 1'b1;
        S_RHI: if (tmr == TW'(RE_HI - 1)) begin
          tmr   <= '0;
          state <= S_OUT;
        end else tmr <= tmr + 1'b1;
        S_OUT: if (out_ready) begin
          rem   <= rem - 1'b1;
          tmr   <= '0;
          state <= (rem == CNT_W'(1)) ? S_IDLE : S_RLO;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_cmd_addr_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_no_read_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_rb_n |-> nand_re_n);

  assert_reject_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_jump && !page_loaded |=> err_nopage && req_ready && nand_we_n);

  assert_fault_unloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_fault) |-> req_ready && !page_loaded);

  assert_bus_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe && nand_we_n);

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: tb/nand_colread_seq_tb_top.sv
`timescale 1ns/1ps
module nand_colread_seq_tb_top;
  localparam int COL_W = 12, ROW_W = 16, CNT_W = 12;
  localparam int RE_LO = 2, RE_HI = 2, WHR = 3, BUSY_MAX = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_jump = 1'b0, out_ready = 1'b1;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [CNT_W-1:0] req_cnt = '0;
  logic req_ready, out_valid, err_nopage, busy_fault;
  logic [7:0] out_data, nand_io_out, nand_io_in;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic nand_rb_n = 1'b1;

  always #4 clk = ~clk;

  nand_colread_seq #(.COL_W(COL_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .RE_LO(RE_LO),
    .RE_HI(RE_HI), .WHR(WHR), .BUSY_MAX(BUSY_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_jump(req_jump), .req_row(req_row), .req_col(req_col), .req_cnt(req_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err_nopage(err_nopage), .busy_fault(busy_fault), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
    .nand_rb_n(nand_rb_n));

  int checks = 0, failures = 0, cyc = 0;
  int rdy_mode = 0, busy_len = 20;

  function automatic logic [7:0] byte_of(int row, int col);
    return 8'((row * 29) ^ (col * 3) ^ (col >> 8) ^ 32'h5A);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // device model and bus monitor, sampled at the falling edge
  logic [7:0] wbyte [0:15];
  bit         wcmd  [0:15];
  int wcnt = 0, aidx = 0, mcol = 0, mrow = 0, ptr = 0, busy_left = 0;
  logic [7:0] obuf [0:63];
  int ocnt = 0, re_falls = 0;
  int lo_viol = 0, hi_viol = 0, whr_viol = 0, rb_viol = 0, hold_viol = 0;
  int low_run = 0, high_run = 0, since_we = 100;
  bit first_after_we = 1'b1, prev_we = 1'b1, prev_re = 1'b1;
  bit prev_ov = 1'b0, prev_ordy = 1'b0;
  logic [7:0] prev_od = '0;

  assign nand_io_in = byte_of(mrow, ptr);

  always @(negedge clk) begin
    since_we++;
    if (!prev_we && nand_we_n) begin
      since_we = 0;
      first_after_we = 1'b1;
      if (wcnt < 16) begin
        wbyte[wcnt] = nand_io_out;
        wcmd[wcnt]  = nand_cle;
      end
      wcnt++;
      if (nand_cle) begin
        if (nand_io_out == 8'h00 || nand_io_out == 8'h05) aidx = 0;
        if (nand_io_out == 8'h30) begin
          ptr = mcol;
          busy_left = busy_len;
          nand_rb_n = 1'b0;
        end
        if (nand_io_out == 8'hE0) ptr = mcol;
      end else if (nand_ale) begin
        case (aidx)
          0: mcol = (mcol & 32'hFF00) | int'(nand_io_out);
          1: mcol = (mcol & 32'h00FF) | (int'(nand_io_out) << 8);
          2: mrow = (mrow & 32'hFF00) | int'(nand_io_out);
          default: mrow = (mrow & 32'h00FF) | (int'(nand_io_out) << 8);
        endcase
        aidx++;
      end
    end else if (busy_left > 0) begin
      busy_left--;
      if (busy_left == 0) nand_rb_n = 1'b1;
    end
    if (prev_re && !nand_re_n) begin
      re_falls++;
      if (since_we < WHR) whr_viol++;
      if (!first_after_we && high_run < RE_HI) hi_viol++;
      first_after_we = 1'b0;
      high_run = 0;
    end
    if (!nand_re_n) low_run++;
    else high_run++;
    if (!prev_re && nand_re_n) begin
      if (low_run != RE_LO) lo_viol++;
      low_run = 0;
      ptr++;
    end
    if (!nand_rb_n && !nand_re_n) rb_viol++;
    if (prev_ov && !prev_ordy && (!out_valid || out_data != prev_od)) hold_viol++;
    if (out_valid && out_ready && ocnt < 64) begin
      obuf[ocnt] = out_data;
      ocnt++;
    end
    prev_we = nand_we_n; prev_re = nand_re_n;
    prev_ov = out_valid; prev_ordy = out_ready; prev_od = out_data;
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      case (rdy_mode)
        0: out_ready = 1'b1;
        1: out_ready = ($urandom % 2) == 0;
        default: out_ready = ($urandom % 5) == 0;
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(bit jump, int row, int col, int cnt);
    @(posedge clk); #2;
    wait (req_ready);
    wcnt = 0; ocnt = 0; re_falls = 0;
    req_valid = 1'b1; req_jump = jump;
    req_row = ROW_W'(row); req_col = COL_W'(col); req_cnt = CNT_W'(cnt);
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_writes(string req, bit jump, int row, int col);
    int n = jump ? 4 : 6;
    bit ok = (wcnt == n);
    logic [7:0] e [0:5];
    if (jump) begin
      e[0] = 8'h05; e[1] = 8'(col); e[2] = 8'(col >> 8); e[3] = 8'hE0;
    end else begin
      e[0] = 8'h00; e[1] = 8'(col); e[2] = 8'(col >> 8);
      e[3] = 8'(row); e[4] = 8'(row >> 8); e[5] = 8'h30;
    end
    for (int i = 0; i < n && ok; i++)
      if (wbyte[i] != e[i] || wcmd[i] != (i == 0 || i == n - 1)) begin
        ok = 1'b0;
        check(1'b0, req, int'(wbyte[i]), int'(e[i]));
      end
    if (ok) check(1'b1, req, wcnt, n);
    else if (wcnt != n) check(1'b0, req, wcnt, n);
  endtask

  task automatic check_bytes(string req, int row, int col, int cnt);
    bit ok = (ocnt == cnt);
    for (int i = 0; i < cnt && ok; i++)
      if (obuf[i] != byte_of(row, col + i)) begin
        ok = 1'b0;
        check(1'b0, req, int'(obuf[i]), int'(byte_of(row, col + i)));
      end
    if (ok) check(1'b1, req, ocnt, cnt);
    else if (ocnt != cnt) check(1'b0, req, ocnt, cnt);
  endtask

  initial begin
    int row, col, cnt;
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(req_ready && !out_valid && !err_nopage && !busy_fault, "R11", req_ready, 1);
    check(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R11", nand_we_n, 1);

    // R6 jump before any page
    issue(1'b1, 0, 100, 4);
    check(err_nopage == 1'b1, "R6", err_nopage, 1);
    check(wcnt == 0 && ocnt == 0, "R6", wcnt, 0);

    // R1 R2 R3 page loads
    for (int k = 0; k < 3; k++) begin
      row = int'($urandom % 65536); col = int'($urandom % 4000); cnt = 1 + int'($urandom % 16);
      rdy_mode = k % 2;
      issue(1'b0, row, col, cnt);
      check_writes("R1", 1'b0, row, col);
      check_bytes("R3", row, col, cnt);
      check(err_nopage == 1'b0, "R6", err_nopage, 0);
    end
    check(rb_viol == 0, "R2", rb_viol, 0);

    // R4 R5 repeated jumps in the loaded page
    for (int k = 0; k < 6; k++) begin
      col = int'($urandom % 4000); cnt = 1 + int'($urandom % 16);
      rdy_mode = 1;
      issue(1'b1, 0, col, cnt);
      check_writes("R4", 1'b1, row, col);
      check_bytes("R5", row, col, cnt);
    end
    // directed edges: columns at 0 and at top of page
    issue(1'b1, 0, 0, 3);
    check_bytes("R5", row, 0, 3);
    issue(1'b1, 0, 4093, 3);
    check_writes("R4", 1'b1, row, 4093);
    check_bytes("R5", row, 4093, 3);

    // R9 heavy backpressure
    rdy_mode = 2;
    issue(1'b1, 0, 777, 16);
    check_bytes("R9", row, 777, 16);
    check(hold_viol == 0, "R9", hold_viol, 0);
    rdy_mode = 0;

    // R10 zero count
    issue(1'b1, 0, 55, 0);
    check(re_falls == 0 && ocnt == 0, "R10", re_falls, 0);
    check_writes("R10", 1'b1, row, 55);

    check(lo_viol == 0, "R8", lo_viol, 0);
    check(hi_viol == 0, "R8", hi_viol, 0);
    check(whr_viol == 0, "R8", whr_viol, 0);

    // R7 busy timeout
    busy_len = 1000;
    issue(1'b0, 1234, 10, 4);
    check(busy_fault == 1'b1, "R7", busy_fault, 1);
    check(ocnt == 0 && re_falls == 0, "R7", ocnt, 0);
    busy_len = 20;
    wait (nand_rb_n);
    issue(1'b1, 0, 10, 2);
    check(err_nopage == 1'b1 && busy_fault == 1'b0, "R7", err_nopage, 1);
    check(wcnt == 0, "R7", wcnt, 0);
    issue(1'b0, 4321, 20, 5);
    check_bytes("R3", 4321, 20, 5);
    check(rb_viol == 0, "R2", rb_viol, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule